// File: doc/BRIEF.md
# Lock Elision Prefix Classifier

This block looks at the legacy prefix bytes of one decoded instruction and decides whether the instruction carries a lock-acquire elision hint, a lock-release elision hint, or neither. When neither applies but a hint byte is present, it says that the byte must be handled as an ordinary legacy prefix. It also flags an instruction whose total length is above the architectural limit. In that case a general-protection fault is raised instead of any hint.

The front end passes in the prefix bytes in fetch order with a count of the valid ones. It also passes the opcode byte, a five-bit operation class from the pre-decoder, a flag for a memory destination, the total instruction length and a feature enable. One cycle later the block returns four registered flags with a valid strobe. Length decoding, ModRM parsing and execution belong to other blocks.

Top module: `elide_hint_classify`

## Requirements
- R1: Only the first `pfx_count` prefix slots are examined, and slot 0 is the earliest fetched. Byte F2h is an acquire-hint prefix, byte F3h is a release-hint prefix and byte F0h is LOCK.
- R2: The acquire or release hint is granted to a read-modify-write class (op_class 1 to 17) only when `mem_dst` is 1 and a LOCK byte is present among the examined slots.
- R3: The exchange class (op_class 18) with `mem_dst` = 1 qualifies for either hint, with or without LOCK.
- R4: Opcodes 88h, 89h, C6h and C7h with `mem_dst` = 1 qualify for the release hint without LOCK. They never qualify for the acquire hint.
- R5: When both F2h and F3h are examined, the one in the highest slot (nearest the opcode) alone selects which hint is considered.
- R6: If `len_total` is greater than 15, `len_fault` is 1 and the acquire hint, the release hint and the legacy flag are all 0.
- R7: With `hint_en` = 0, no hint is asserted. Any examined F2h/F3h raises `legacy_pfx`.
- R8: If an F2h/F3h is examined but the selected hint is not granted, `legacy_pfx` is 1. All other op_class values (0, 19 to 31) never qualify by class.
- R9: The outputs appear one clock after `in_valid`, and `out_valid` mirrors `in_valid` delayed by one cycle. All flags are 0 while `out_valid` is 0.
- R10: `acq_hint` and `rel_hint` are never 1 together.
- R11: Bytes in slots at or beyond `pfx_count` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction fields valid this cycle |
| pfx_bytes | input | 8*PFX_SLOTS | Prefix bytes, slot i at bits [8i+7:8i] |
| pfx_count | input | CNT_W | Number of valid prefix slots |
| opcode | input | 8 | Primary opcode byte |
| op_class | input | 5 | Pre-decoded operation class |
| mem_dst | input | 1 | Destination operand is memory |
| hint_en | input | 1 | Elision hint feature enabled |
| len_total | input | LEN_W | Total instruction length in bytes |
| out_valid | output | 1 | Result valid |
| acq_hint | output | 1 | Acquire-enabled instruction |
| rel_hint | output | 1 | Release-enabled instruction |
| legacy_pfx | output | 1 | F2h/F3h to be treated as an ordinary prefix |
| len_fault | output | 1 | Length limit exceeded |

## Verification
Each result register holds the flags for one instruction only, so a stale or wrong internal state shows up at the ports one cycle after the offending input. It appears either as a wrong flag combination or as a flag raised while `out_valid` is low. A scan that picks the earliest hint byte instead of the last, or that reads slots past the count, changes the flags of the very next result. The sweep covers every four-slot ordering of LOCK, both hint bytes and a neutral prefix, at every count, so such an error is exposed within the first few hundred vectors.

// File: rtl/elide_hint_classify.sv
module elide_hint_classify #(
  parameter int PFX_SLOTS = 4,
  parameter int LEN_W     = 5,
  parameter int LEN_LIMIT = 15,
  localparam int CNT_W    = $clog2(PFX_SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [8*PFX_SLOTS-1:0] pfx_bytes,
  input  logic [CNT_W-1:0]       pfx_count,
  input  logic [7:0]             opcode,
  input  logic [4:0]             op_class,
  input  logic                   mem_dst,
  input  logic                   hint_en,
  input  logic [LEN_W-1:0]       len_total,
  output logic                   out_valid,
  output logic                   acq_hint,
  output logic                   rel_hint,
  output logic                   legacy_pfx,
  output logic                   len_fault
);

  localparam logic [7:0] B_LOCK = 8'hF0;
  localparam logic [7:0] B_ACQ  = 8'hF2;
  localparam logic [7:0] B_REL  = 8'hF3;
  localparam logic [4:0] CLS_RMW_LO = 5'd1;
  localparam logic [4:0] CLS_RMW_HI = 5'd17;
  localparam logic [4:0] CLS_XCHG   = 5'd18;

  typedef enum logic [1:0] {SEL_NONE, SEL_ACQ, SEL_REL} sel_t;

  logic has_lock;
  sel_t sel;

  always_comb begin
    has_lock = 1'b0;
    sel      = SEL_NONE;
    for (int i = 0; i < PFX_SLOTS; i++) begin
      if (int'(pfx_count) > i) begin
        if (pfx_bytes[8*i +: 8] == B_LOCK) has_lock = 1'b1;
        if (pfx_bytes[8*i +: 8] == B_ACQ)  sel = SEL_ACQ;
        if (pfx_bytes[8*i +: 8] == B_REL)  sel = SEL_REL;
      end
    end
  end

  logic is_rmw, is_xchg, is_store_mov, too_long;
  assign is_rmw       = (op_class >= CLS_RMW_LO) && (op_class <= CLS_RMW_HI);
  assign is_xchg      = (op_class == CLS_XCHG);
  assign is_store_mov = (opcode == 8'h88) || (opcode == 8'h89) ||
                        (opcode == 8'hC6) || (opcode == 8'hC7);
  assign too_long     = int'(len_total) > LEN_LIMIT;

  logic acq_ok, rel_ok, acq_n, rel_n, leg_n;
  assign acq_ok = mem_dst && ((is_rmw && has_lock) || is_xchg);
  assign rel_ok = mem_dst && ((is_rmw && has_lock) || is_xchg || is_store_mov);
  assign acq_n  = !too_long && hint_en && (sel == SEL_ACQ) && acq_ok;
  assign rel_n  = !too_long && hint_en && (sel == SEL_REL) && rel_ok;
  assign leg_n  = !too_long && (sel != SEL_NONE) && !acq_n && !rel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      acq_hint   <= 1'b0;
      rel_hint   <= 1'b0;
      legacy_pfx <= 1'b0;
      len_fault  <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      acq_hint   <= in_valid && acq_n;
      rel_hint   <= in_valid && rel_n;
      legacy_pfx <= in_valid && leg_n;
      len_fault  <= in_valid && too_long;
    end
  end

endmodule

module elide_hint_props #(
  parameter int LEN_W     = 5,
  parameter int LEN_LIMIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             hint_en,
  input logic [LEN_W-1:0] len_total,
  input logic             out_valid,
  input logic             acq_hint,
  input logic             rel_hint,
  input logic             legacy_pfx,
  input logic             len_fault
);

  p_one_hint_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_hint && rel_hint));

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !acq_hint && !rel_hint && !legacy_pfx && !len_fault));

  p_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && int'(len_total) > LEN_LIMIT) |=> (len_fault && !acq_hint && !rel_hint && !legacy_pfx));

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hint_en) |=> (!acq_hint && !rel_hint));

  p_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_pfx |-> (!acq_hint && !rel_hint));

endmodule

bind elide_hint_classify elide_hint_props #(.LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hint_en(hint_en),
  .len_total(len_total), .out_valid(out_valid), .acq_hint(acq_hint),
  .rel_hint(rel_hint), .legacy_pfx(legacy_pfx), .len_fault(len_fault)
);

// File: tb/sim_elide_hint_classify.sv
module sim_elide_hint_classify;
  localparam int SLOTS = 4;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [8*SLOTS-1:0] pfx_bytes = '0;
  logic [CW-1:0] pfx_count = '0;
  logic [7:0] opcode = '0;
  logic [4:0] op_class = '0;
  logic mem_dst = 1'b0;
  logic hint_en = 1'b0;
  logic [4:0] len_total = '0;
  logic out_valid, acq_hint, rel_hint, legacy_pfx, len_fault;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  elide_hint_classify u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_bytes(pfx_bytes),
    .pfx_count(pfx_count), .opcode(opcode), .op_class(op_class),
    .mem_dst(mem_dst), .hint_en(hint_en), .len_total(len_total),
    .out_valid(out_valid), .acq_hint(acq_hint), .rel_hint(rel_hint),
    .legacy_pfx(legacy_pfx), .len_fault(len_fault)
  );

  function automatic logic [3:0] model(input logic [8*SLOTS-1:0] b, input int cnt,
      input logic [7:0] op, input int cls, input bit mem, input bit en, input int len);
    bit lk = 0; int s = 0; bit ok_a, ok_r, a, r, f;
    for (int i = 0; i < cnt; i++) begin
      if (b[8*i +: 8] == 8'hF0) lk = 1;
      else if (b[8*i +: 8] == 8'hF2) s = 1;
      else if (b[8*i +: 8] == 8'hF3) s = 2;
    end
    f = len > 15;
    ok_a = mem && ((cls >= 1 && cls <= 17 && lk) || cls == 18);
    ok_r = ok_a || (mem && (op == 8'h88 || op == 8'h89 || op == 8'hC6 || op == 8'hC7));
    a = !f && en && s == 1 && ok_a;
    r = !f && en && s == 2 && ok_r;
    return {a, r, (!f && s != 0 && !a && !r), f};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    logic [4:0] got = {out_valid, acq_hint, rel_hint, legacy_pfx, len_fault};
    n_checks++;
    if (got !== {1'b1, exp}) begin
      n_fail++;
      $display("FAIL %s: got v/acq/rel/leg/flt=%b expected %b", tag, got, {1'b1, exp});
    end
  endtask

  task automatic apply(input logic [8*SLOTS-1:0] b, input int cnt, input logic [7:0] op,
      input int cls, input bit mem, input bit en, input int len, input string tag);
    @(negedge clk);
    pfx_bytes = b; pfx_count = CW'(cnt); opcode = op; op_class = 5'(cls);
    mem_dst = mem; hint_en = en; len_total = 5'(len); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, model(b, cnt, op, cls, mem, en, len));
  endtask

  function automatic logic [7:0] digit(input int d);
    case (d)
      0: return 8'hF0;
      1: return 8'hF2;
      2: return 8'hF3;
      default: return 8'h66;
    endcase
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if ({out_valid, acq_hint, rel_hint, legacy_pfx, len_fault} !== 5'b0) begin
      n_fail++; $display("FAIL R9 reset: got %b expected 00000",
        {out_valid, acq_hint, rel_hint, legacy_pfx, len_fault});
    end
    rst_n = 1'b1;

    // R5: F3 F2 then store opcode C6 -> acquire nearest, not eligible -> legacy
    apply({8'h00, 8'hF2, 8'hF3}, 2, 8'hC6, 0, 1, 1, 5, "R5 F3F2-C6");
    // R5: F2 F0 F3 on locked rmw -> release
    apply({8'hF3, 8'hF0, 8'hF2}, 3, 8'h01, 1, 1, 1, 6, "R5 F2F0F3");
    // R1: a single LOCK with no hint byte gives no flags
    apply({24'h0, 8'hF0}, 1, 8'h01, 1, 1, 1, 4, "R1 lock only");
    // R11: hint byte beyond count is ignored
    apply({16'h0, 8'hF2, 8'hF0}, 1, 8'h01, 1, 1, 1, 4, "R11 past count");
    // R6 boundary: 15 ok, 16 fault
    apply({16'h0, 8'hF2, 8'hF0}, 2, 8'h87, 18, 1, 1, 15, "R6 len15");
    apply({16'h0, 8'hF2, 8'hF0}, 2, 8'h87, 18, 1, 1, 16, "R6 len16");
    // R9: idle cycle after a result
    @(negedge clk);
    n_checks++;
    if ({out_valid, acq_hint, rel_hint, legacy_pfx, len_fault} !== 5'b0) begin
      n_fail++; $display("FAIL R9 idle: got %b expected 00000",
        {out_valid, acq_hint, rel_hint, legacy_pfx, len_fault});
    end

    for (int pat = 0; pat < 256; pat++) begin
      for (int cnt = 0; cnt <= SLOTS; cnt++) begin
        for (int sc = 0; sc < 12; sc++) begin
          logic [8*SLOTS-1:0] b;
          int cls; logic [7:0] op; bit mem; bit en; int len;
          bit has2, has3; string tag;
          for (int k = 0; k < SLOTS; k++) b[8*k +: 8] = digit((pat >> (2*k)) & 3);
          mem = 1; en = 1;
          case (sc)
            0: begin cls = 1;  op = 8'h01; end
            1: begin cls = 17; op = 8'h0F; end
            2: begin cls = 18; op = 8'h87; end
            3: begin cls = 0;  op = 8'h89; end
            4: begin cls = 0;  op = 8'hC6; end
            5: begin cls = 0;  op = 8'h88; mem = 0; end
            6: begin cls = 9;  op = 8'hFF; mem = 0; end
            7: begin cls = 20; op = 8'h01; end
            8: begin cls = 1;  op = 8'h01; en = 0; end
            9: begin cls = 19; op = 8'hC7; end
            10: begin cls = 18; op = 8'h87; en = 0; end
            default: begin cls = 0; op = 8'h8B; end
          endcase
          len = 14 + ((pat + sc + cnt) % 3);
          has2 = 0; has3 = 0;
          for (int k = 0; k < cnt; k++) begin
            if (b[8*k +: 8] == 8'hF2) has2 = 1;
            if (b[8*k +: 8] == 8'hF3) has3 = 1;
          end
          if (len > 15) tag = "R6";
          else if (!en) tag = "R7";
          else if (has2 && has3) tag = "R5";
          else if (sc == 3 || sc == 4 || sc == 9) tag = "R4";
          else if (sc == 2) tag = "R3";
          else if (sc == 0 || sc == 1 || sc == 6) tag = "R2";
          else tag = "R8";
          apply(b, cnt, op, cls, mem, en, len, tag);
          if (acq_hint && rel_hint) begin
            n_checks++; n_fail++;
            $display("FAIL R10: both hints set, expected at most one");
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule